// File: doc/BRIEF.md
# Urgency-aware round-robin DMA arbiter

The arbiter decides which of several DMA pipelines may next use a shared memory request port. Each pipeline shows a request bit and a static high-priority bit. An urgency bit is also supplied for each pipeline by external buffer-fill logic. A two-bit mode field turns the urgency mechanism on or off. Each time the advance strobe is pulsed, the arbiter registers a one-hot grant and a valid flag. These outputs stay unchanged until the next strobe.

The winner is chosen by round-robin inside one eligible subset, picked in tiers:

- When the urgency mechanism is enabled, high-priority requesters with urgency set are chosen first.
- Failing that, all high-priority requesters are eligible.
- Failing that, all requesters are eligible.

Each tier keeps its own rotation pointer. A burst of urgent service therefore does not disturb the fairness order of the other tiers.

Top module: `urg_rr_arb`

## Requirements
- R1: After reset `valid_o` is 0 and `grant_o` is all zeros. Every tier pointer starts at pipeline 0, so the first grant in any tier goes to the lowest-numbered eligible pipeline.
- R2: `grant_o` and `valid_o` change only on a rising clock edge where `advance_i` is 1. Otherwise they hold their value, even when the inputs change.
- R3: On an advance with no request bit set, `valid_o` becomes 0, `grant_o` becomes zero, and no tier pointer moves.
- R4: If no high-priority pipeline is requesting, the grant goes round-robin among all requesting pipelines.
- R5: If the urgent tier is empty or disabled and at least one high-priority pipeline requests, the grant goes round-robin among the requesting high-priority pipelines only.
- R6: `mode_i` == 2 enables the urgency mechanism. The values 0, 1 and 3 disable it, and in that case urgency bits have no effect.
- R7: With the mechanism enabled, if any pipeline has request, high-priority and urgency all set, the grant goes round-robin among exactly those pipelines.
- R8: Urgency bits of normal-priority pipelines are ignored. If no high-priority requester is urgent, selection falls back to the R5/R4 scheme.
- R9: Each tier has its own pointer. Only a grant made in a tier moves that tier's pointer, and it moves to the index after the granted pipeline, wrapping from N-1 to 0.
- R10: `grant_o` has at most one bit set. It has exactly one bit set when `valid_o` is 1, and that bit belongs to a pipeline that was requesting at the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_PIPES | Request bit per pipeline |
| hipri_i | input | N_PIPES | Static high-priority bit per pipeline |
| urgent_i | input | N_PIPES | Urgency bit per pipeline |
| mode_i | input | 2 | Urgency mechanism mode (2 = enabled) |
| advance_i | input | 1 | Strobe: register a new grant |
| grant_o | output | N_PIPES | One-hot grant |
| valid_o | output | 1 | Grant is valid |

## Verification
All pipelines requesting with no high-priority bits shows the plain rotation, including the wrap from the top index back to 0. An empty request vector, followed by a full one, shows that a grantless advance leaves the pointer alone. Alternating high-priority masks and switching back to all-normal show that the high-priority tier and the normal tier rotate independently. Urgent patterns are applied under mode 2 and again under modes 0 and 1, with urgency set only on normal pipelines and with inputs changed between strobes. These separate correct urgent narrowing, correct mode decoding, the fallback, and grant holding.

// File: rtl/urg_rr_pkg.sv
package urg_rr_pkg;
  localparam int unsigned NUM_TIERS = 3;
  localparam logic [1:0] MODE_URGENT = 2'd2;

  typedef enum logic [1:0] {
    TIER_URG  = 2'd0,
    TIER_HI   = 2'd1,
    TIER_NORM = 2'd2
  } tier_e;
endpackage

// File: rtl/urg_rr_eligible.sv
module urg_rr_eligible
  import urg_rr_pkg::*;
#(
  parameter int unsigned N_PIPES = 4
) (
  input  logic [N_PIPES-1:0] req_i,
  input  logic [N_PIPES-1:0] hipri_i,
  input  logic [N_PIPES-1:0] urgent_i,
  input  logic [1:0]         mode_i,
  output logic [N_PIPES-1:0] cand_o,
  output tier_e              tier_o,
  output logic               any_o
);
  logic [N_PIPES-1:0] hi_set, urg_set;
  logic               urg_en;

  assign urg_en  = (mode_i == MODE_URGENT);
  assign hi_set  = req_i & hipri_i;
  // normal pipelines' urgency never reaches the urgent set
  assign urg_set = urg_en ? (hi_set & urgent_i) : '0;

  always_comb begin
    if (|urg_set) begin
      tier_o = TIER_URG;
      cand_o = urg_set;
    end else if (|hi_set) begin
      tier_o = TIER_HI;
      cand_o = hi_set;
    end else begin
      tier_o = TIER_NORM;
      cand_o = req_i;
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/urg_rr_pick.sv
module urg_rr_pick #(
  parameter int unsigned N_PIPES = 4,
  localparam int unsigned PTR_W = (N_PIPES > 1) ? $clog2(N_PIPES) : 1
) (
  input  logic [N_PIPES-1:0] cand_i,
  input  logic [PTR_W-1:0]   ptr_i,
  output logic [PTR_W-1:0]   idx_o,
  output logic [N_PIPES-1:0] onehot_o
);
  always_comb begin
    int pos;
    idx_o = '0;
    pos   = 0;
    // descending scan: the smallest offset from the pointer wins
    for (int k = N_PIPES - 1; k >= 0; k--) begin
      pos = int'(ptr_i) + k;
      if (pos >= int'(N_PIPES)) pos = pos - int'(N_PIPES);
      if (cand_i[pos]) idx_o = PTR_W'(pos);
    end
  end

  always_comb begin
    onehot_o = '0;
    if (|cand_i) onehot_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/urg_rr_ptr_bank.sv
module urg_rr_ptr_bank
  import urg_rr_pkg::*;
#(
  parameter int unsigned N_PIPES = 4,
  localparam int unsigned PTR_W = (N_PIPES > 1) ? $clog2(N_PIPES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  tier_e            tier_i,
  input  logic [PTR_W-1:0] idx_i,
  output logic [NUM_TIERS-1:0][PTR_W-1:0] ptrs_o
);
  logic [PTR_W-1:0] nxt_ptr;

  assign nxt_ptr = (idx_i == PTR_W'(N_PIPES - 1)) ? '0 : idx_i + 1'b1;

  for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptrs_o[t] <= '0;
      end else if (upd_i && (int'(tier_i) == t)) begin
        ptrs_o[t] <= nxt_ptr;
      end
    end
  end
endmodule

// File: rtl/urg_rr_arb.sv
module urg_rr_arb
  import urg_rr_pkg::*;
#(
  parameter int unsigned N_PIPES = 4,
  localparam int unsigned PTR_W = (N_PIPES > 1) ? $clog2(N_PIPES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PIPES-1:0] req_i,
  input  logic [N_PIPES-1:0] hipri_i,
  input  logic [N_PIPES-1:0] urgent_i,
  input  logic [1:0]         mode_i,
  input  logic               advance_i,
  output logic [N_PIPES-1:0] grant_o,
  output logic               valid_o
);
  logic [N_PIPES-1:0]              cand, pick_oh;
  tier_e                           tier;
  logic                            any_req;
  logic [NUM_TIERS-1:0][PTR_W-1:0] ptrs;
  logic [PTR_W-1:0]                pick_idx;

  urg_rr_eligible #(.N_PIPES(N_PIPES)) u_elig (
    .req_i    (req_i),
    .hipri_i  (hipri_i),
    .urgent_i (urgent_i),
    .mode_i   (mode_i),
    .cand_o   (cand),
    .tier_o   (tier),
    .any_o    (any_req)
  );

  urg_rr_pick #(.N_PIPES(N_PIPES)) u_pick (
    .cand_i   (cand),
    .ptr_i    (ptrs[tier]),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  urg_rr_ptr_bank #(.N_PIPES(N_PIPES)) u_ptrs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (advance_i & any_req),
    .tier_i (tier),
    .idx_i  (pick_idx),
    .ptrs_o (ptrs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= '0;
      valid_o <= 1'b0;
    end else if (advance_i) begin
      grant_o <= any_req ? pick_oh : '0;
      valid_o <= any_req;
    end
  end
endmodule

// File: rtl/urg_rr_arb_chk.sv
module urg_rr_arb_chk #(
  parameter int unsigned N_PIPES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_PIPES-1:0] req_i,
  input logic [N_PIPES-1:0] hipri_i,
  input logic [N_PIPES-1:0] urgent_i,
  input logic [1:0]         mode_i,
  input logic               advance_i,
  input logic [N_PIPES-1:0] grant_o,
  input logic               valid_o
);
  // R10
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o ? ($countones(grant_o) == 1) : (grant_o == '0));

  // R10
  grant_from_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |=> ((grant_o & ~$past(req_i)) == '0));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> ($stable(grant_o) && $stable(valid_o)));

  // R3
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && req_i == '0) |=> !valid_o);

  // R5
  hipri_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && (req_i & hipri_i) != '0) |=> ((grant_o & ~$past(hipri_i)) == '0));

  // R7
  urgent_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && mode_i == 2'd2 && (req_i & hipri_i & urgent_i) != '0)
      |=> ((grant_o & ~$past(hipri_i & urgent_i)) == '0));
endmodule

bind urg_rr_arb urg_rr_arb_chk #(.N_PIPES(N_PIPES)) u_chk (.*);

// File: tb/urg_rr_arb_test.sv
`timescale 1ns/1ps
module urg_rr_arb_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0, hipri = '0, urgent = '0;
  logic [1:0]   mode = 2'd0;
  logic         adv = 1'b0;
  logic [N-1:0] grant;
  logic         valid;
  int           n_chk = 0, n_bad = 0;
  bit           done = 0;

  always #2.5 clk = ~clk;

  urg_rr_arb #(.N_PIPES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .hipri_i(hipri),
    .urgent_i(urgent), .mode_i(mode), .advance_i(adv),
    .grant_o(grant), .valid_o(valid)
  );

  task automatic check(string tag, logic v_exp, logic [N-1:0] g_exp);
    n_chk++;
    if (valid !== v_exp || grant !== g_exp) begin
      n_bad++;
      $display("FAIL %s: valid=%b grant=%b expected valid=%b grant=%b",
               tag, valid, grant, v_exp, g_exp);
    end
  endtask

  // one-cycle strobe, then sample after the edge has registered the grant
  task automatic step(string tag, logic v_exp, logic [N-1:0] g_exp);
    @(negedge clk) adv = 1'b1;
    @(negedge clk) adv = 1'b0;
    check(tag, v_exp, g_exp);
  endtask

  task automatic t_reset;
    check("R1 reset", 1'b0, 4'b0000);
  endtask

  task automatic t_normal_rr;
    req = 4'b1111; hipri = '0; urgent = '0; mode = 2'd0;
    step("R1 first from 0", 1'b1, 4'b0001);
    step("R4 rr 1", 1'b1, 4'b0010);
    step("R4 rr 2", 1'b1, 4'b0100);
    step("R4 rr 3", 1'b1, 4'b1000);
    step("R9 wrap", 1'b1, 4'b0001);
  endtask

  task automatic t_idle;
    req = '0;
    step("R3 idle", 1'b0, 4'b0000);
    req = 4'b1111;
    step("R3 ptr kept", 1'b1, 4'b0010);
  endtask

  task automatic t_hipri;
    hipri = 4'b1010;
    step("R5 hi 1", 1'b1, 4'b0010);
    step("R5 hi 3", 1'b1, 4'b1000);
    step("R5 hi wrap", 1'b1, 4'b0010);
    hipri = '0;
    step("R9 normal ptr separate", 1'b1, 4'b0100);
  endtask

  task automatic t_urgent;
    mode = 2'd2; hipri = 4'b1111; urgent = 4'b0110;
    step("R7 urg 1", 1'b1, 4'b0010);
    step("R7 urg 2", 1'b1, 4'b0100);
    step("R7 urg wrap", 1'b1, 4'b0010);
    hipri = 4'b0011; urgent = 4'b1100;
    step("R8 normal urgency ignored", 1'b1, 4'b0001);
  endtask

  task automatic t_modes;
    hipri = 4'b1111; urgent = 4'b0001; mode = 2'd0;
    step("R6 mode0 ignores urgency", 1'b1, 4'b0010);
    mode = 2'd1; urgent = 4'b1000;
    step("R6 mode1 ignores urgency", 1'b1, 4'b0100);
  endtask

  task automatic t_hold;
    req = '0; mode = 2'd2; urgent = 4'b1111;
    repeat (3) @(negedge clk);
    check("R2 hold", 1'b1, 4'b0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_normal_rr();
    t_idle();
    t_hipri();
    t_urgent();
    t_modes();
    t_hold();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule